// File: doc/BRIEF.md
# Interleaved SEC-DED Byte Memory

This block is the data memory of an 8-bit microcontroller core, built to survive radiation upsets. Each byte written is cut into a low and a high nibble. Each nibble becomes an eight-bit extended Hamming codeword, and the two codewords are woven bit by bit into one 16-bit storage word. Because neighbouring physical bits belong to different codewords, an upset that hits two adjacent cells damages each codeword in only one place, and both damaged places can be repaired.

On a read, the stored word is split back into its two codewords. Each codeword is decoded on its own: a single error is repaired and a double error is reported. The byte comes back together with a corrected flag and an uncorrectable flag. A one-cycle fault pulse goes out whenever either flag is delivered, and the core can use it as an interrupt source. Requests enter on a valid/ready channel. Read results leave on a valid/ready channel that holds one result. A request is accepted only when the result slot is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the result holds steady and `req_ready` stays low. For fault-injection testing, a write also carries a 16-bit mask that is XORed onto the encoded word before it is stored.

Top module: `ilv_secded_ram`

## Requirements
- R1: While reset is held and after it is released, `rsp_valid` and `fault` are low and `req_ready` is high.
- R2: A read accepted in cycle N (`req_valid`, `req_ready`, `req_we`=0) gives `rsp_valid` high in cycle N+1, with `rsp_data` equal to the last byte written to that address. A write accepted in cycle N is seen by a read accepted in cycle N+1 or later.
- R3: Each nibble codeword is laid out as bit0=p1, bit1=p2, bit2=d0, bit3=p4, bit4=d1, bit5=d2, bit6=d3, bit7=overall parity. Here d0..d3 are the nibble bits, least significant first, and p1, p2 and p4 are even parity over codeword positions {1,3,5,7}, {2,3,6,7} and {4,5,6,7}. Storage bit 2i holds bit i of the low-nibble codeword and storage bit 2i+1 holds bit i of the high-nibble codeword.
- R4: If one bit of a codeword is in error, the read returns the original nibble and `rsp_corr` is high.
- R5: Two flipped storage bits 2i and 2i+1, which are adjacent and lie in different codewords, are both corrected: the original byte comes back with `rsp_corr` high and `rsp_uncorr` low.
- R6: If two bits of the same codeword are in error, `rsp_uncorr` is high, and that nibble is returned as the raw data bits at codeword positions 2, 4, 5 and 6, with no repair.
- R7: An error confined to the overall parity bit (storage bit 14 or 15) gives `rsp_corr` high and the data unchanged.
- R8: `fault` is high for exactly the cycles in which a result with `rsp_corr` or `rsp_uncorr` is handed over (`rsp_valid` and `rsp_ready`). The flags are per byte: `rsp_corr` is high if either codeword was repaired, and `rsp_uncorr` is high if either had a double error. Both can be high at once.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` and the flags hold steady and `req_ready` is low.
- R10: The write mask `req_inj` is XORed onto the stored word. The damage stays in place, so repeated reads of that address report the same result.
- R11: The depth is a parameter from 192 to 368 bytes, and the last address, DEPTH-1, stores and returns data like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | 8 | Write byte |
| req_inj | input | 16 | Error mask XORed onto the stored word on write |
| rsp_valid | output | 1 | Read result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | 8 | Corrected read byte |
| rsp_corr | output | 1 | A codeword of the result was repaired |
| rsp_uncorr | output | 1 | A codeword of the result has a double error |
| fault | output | 1 | Pulse when a flagged result is handed over |

## Verification
A read result is due exactly one cycle after its request is accepted. From then on it stays valid, unchanged, until the cycle in which `rsp_ready` takes it. The fault pulse falls in that hand-over cycle and in no other. The bench samples every output one nanosecond after the falling edge and compares each one, every cycle, with a model that tracks acceptances, pending results and stored masks. The model therefore expects the response in the cycle after acceptance and keeps expecting it through every stalled cycle. Randomised stalls on `rsp_ready` exercise the hold and stall cases.

// File: rtl/ilv_secded_pkg.sv
package ilv_secded_pkg;
  localparam int NIB_W   = 4;
  localparam int CW_W    = 8;
  localparam int LANES   = 2;
  localparam int BYTE_W  = NIB_W * LANES;
  localparam int STORE_W = CW_W * LANES;
  typedef logic [CW_W-1:0]  cw_t;
  typedef logic [NIB_W-1:0] nib_t;
endpackage

// File: rtl/ilv_ham84_enc.sv
module ilv_ham84_enc
  import ilv_secded_pkg::*;
(
  input  nib_t nib,
  output cw_t  cw
);
  logic [6:0] core;
  always_comb begin
    core[2] = nib[0];
    core[4] = nib[1];
    core[5] = nib[2];
    core[6] = nib[3];
    core[0] = nib[0] ^ nib[1] ^ nib[3];
    core[1] = nib[0] ^ nib[2] ^ nib[3];
    core[3] = nib[1] ^ nib[2] ^ nib[3];
    cw = {^core, core};
  end
endmodule

// File: rtl/ilv_ham84_dec.sv
module ilv_ham84_dec
  import ilv_secded_pkg::*;
(
  input  cw_t  cw,
  output nib_t nib,
  output logic corr,
  output logic uncorr
);
  logic [2:0] syn;
  logic       par_bad;
  cw_t        fixed;

  always_comb begin
    syn[0]  = cw[0] ^ cw[2] ^ cw[4] ^ cw[6];
    syn[1]  = cw[1] ^ cw[2] ^ cw[5] ^ cw[6];
    syn[2]  = cw[3] ^ cw[4] ^ cw[5] ^ cw[6];
    par_bad = ^cw;
    fixed   = cw;
    corr    = 1'b0;
    uncorr  = 1'b0;
    if (par_bad) begin
      // odd error count: repair the pointed position (syn==0 means parity bit)
      corr = 1'b1;
      for (int i = 0; i < 7; i++) begin
        if (syn == 3'(i + 1)) fixed[i] = ~cw[i];
      end
    end else if (syn != 3'd0) begin
      uncorr = 1'b1;
    end
    nib = {fixed[6], fixed[5], fixed[4], fixed[2]};
  end
endmodule

// File: rtl/ilv_secded_store.sv
module ilv_secded_store #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wword,
  output logic [WIDTH-1:0] rword
);
  localparam logic [AW:0] LIMIT = (AW + 1)'(DEPTH);
  logic [WIDTH-1:0] mem [DEPTH];
  logic in_range;

  assign in_range = {1'b0, addr} < LIMIT;

  always_ff @(posedge clk) begin
    if (wr_en && in_range) mem[addr] <= wword;
    if (rd_en && in_range) rword <= mem[addr];
  end
endmodule

// File: rtl/ilv_secded_ram.sv
module ilv_secded_ram
  import ilv_secded_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_we,
  input  logic [AW-1:0]      req_addr,
  input  logic [BYTE_W-1:0]  req_wdata,
  input  logic [STORE_W-1:0] req_inj,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [BYTE_W-1:0]  rsp_data,
  output logic               rsp_corr,
  output logic               rsp_uncorr,
  output logic               fault
);
  logic               acc, wr_acc, rd_acc;
  logic [STORE_W-1:0] enc_word, rd_word;
  cw_t                cw_w [LANES];
  cw_t                cw_r [LANES];
  logic [LANES-1:0]   lane_c, lane_u;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr_acc    = acc && req_we;
  assign rd_acc    = acc && !req_we;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ilv_ham84_enc u_enc (
      .nib (req_wdata[l*NIB_W +: NIB_W]),
      .cw  (cw_w[l])
    );
    for (genvar i = 0; i < CW_W; i++) begin : g_bit
      assign enc_word[i*LANES + l] = cw_w[l][i];
      assign cw_r[l][i]            = rd_word[i*LANES + l];
    end
    ilv_ham84_dec u_dec (
      .cw     (cw_r[l]),
      .nib    (rsp_data[l*NIB_W +: NIB_W]),
      .corr   (lane_c[l]),
      .uncorr (lane_u[l])
    );
  end

  ilv_secded_store #(.DEPTH(DEPTH), .WIDTH(STORE_W), .AW(AW)) u_store (
    .clk   (clk),
    .wr_en (wr_acc),
    .rd_en (rd_acc),
    .addr  (req_addr),
    .wword (enc_word ^ req_inj),
    .rword (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          rsp_valid <= 1'b0;
    else if (rd_acc)     rsp_valid <= 1'b1;
    else if (rsp_ready)  rsp_valid <= 1'b0;
  end

  assign rsp_corr   = rsp_valid && (|lane_c);
  assign rsp_uncorr = rsp_valid && (|lane_u);
  assign fault      = rsp_valid && rsp_ready && (rsp_corr || rsp_uncorr);
endmodule

// File: rtl/ilv_secded_ram_chk.sv
module ilv_secded_ram_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_we,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [7:0]    rsp_data,
  input logic          rsp_corr,
  input logic          rsp_uncorr,
  input logic          fault
);
  p_rd_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_we) |=> rsp_valid);

  p_rsp_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready && !req_we));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_data) && $stable(rsp_corr) && $stable(rsp_uncorr)));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_fault_hs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (rsp_valid && rsp_ready));

  p_flag_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_corr || rsp_uncorr) |-> rsp_valid);

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!rsp_valid && !fault));
endmodule

bind ilv_secded_ram ilv_secded_ram_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_we     (req_we),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data),
  .rsp_corr   (rsp_corr),
  .rsp_uncorr (rsp_uncorr),
  .fault      (fault)
);

// File: tb/ilv_secded_ram_bench.sv
`timescale 1ns/1ps
module ilv_secded_ram_bench;
  localparam int DEPTH = 256;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_wdata = '0;
  logic [15:0]   req_inj = '0;
  logic          req_ready, rsp_valid, rsp_corr, rsp_uncorr, fault;
  logic          rsp_ready = 1'b1;
  logic [7:0]    rsp_data;

  always #2.5 clk = ~clk;

  ilv_secded_ram #(.DEPTH(DEPTH)) u_ilv_secded_ram (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_inj(req_inj),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_corr(rsp_corr), .rsp_uncorr(rsp_uncorr), .fault(fault)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  bit bp_mode = 0;
  bit mon_acc = 0;

  // reference model state
  logic [7:0]  m_data [DEPTH];
  logic [15:0] m_mask [DEPTH];
  bit          e_valid = 0;
  logic [7:0]  e_data;
  bit          e_corr, e_uncorr;
  string       cur_tag = "R2", e_tag = "R2";

  task automatic check(input string tag, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // expected result of reading byte d stored with error mask m (R3, R4, R6, R7)
  task automatic model_read(input logic [7:0] d, input logic [15:0] m,
                            output logic [7:0] od, output bit c, output bit u);
    od = d; c = 0; u = 0;
    for (int l = 0; l < 2; l++) begin
      logic [7:0] lm;
      for (int i = 0; i < 8; i++) lm[i] = m[2*i + l];
      if ($countones(lm) == 1) c = 1;
      else if ($countones(lm) >= 2) begin
        u = 1;
        od[4*l +: 4] = d[4*l +: 4] ^ {lm[6], lm[5], lm[4], lm[2]};
      end
    end
  endtask

  always @(negedge clk) rsp_ready = bp_mode ? 1'($urandom % 2) : 1'b1;

  // monitor: samples after inputs settle, compares, then advances the model
  always begin
    @(negedge clk); #1;
    if (!rst_n) begin
      check("R1", "req_ready in reset", int'(req_ready), 1);
      check("R1", "rsp_valid in reset", int'(rsp_valid), 0);
      check("R1", "fault in reset", int'(fault), 0);
      e_valid = 0; mon_acc = 0;
    end else begin
      bit mready, nxt;
      check(e_tag, "rsp_valid", int'(rsp_valid), int'(e_valid));
      mready = !e_valid || rsp_ready;
      check("R9", "req_ready", int'(req_ready), int'(mready));
      check("R8", "fault", int'(fault), int'(e_valid && rsp_ready && (e_corr || e_uncorr)));
      if (e_valid) begin
        check(e_tag, "rsp_data", int'(rsp_data), int'(e_data));
        check(e_tag, "rsp_corr", int'(rsp_corr), int'(e_corr));
        check(e_tag, "rsp_uncorr", int'(rsp_uncorr), int'(e_uncorr));
      end
      nxt = e_valid && !rsp_ready;
      mon_acc = req_valid && mready;
      if (mon_acc) begin
        if (req_we) begin
          m_data[req_addr] = req_wdata;
          m_mask[req_addr] = req_inj;
        end else begin
          nxt = 1;
          model_read(m_data[req_addr], m_mask[req_addr], e_data, e_corr, e_uncorr);
          e_tag = cur_tag;
        end
      end
      e_valid = nxt;
    end
  end

  task automatic issue(input bit we, input int a, input logic [7:0] d,
                       input logic [15:0] m, input string tag);
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = AW'(a); req_wdata = d; req_inj = m;
    cur_tag = tag;
    do @(posedge clk); while (!mon_acc);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wr(input int a, input logic [7:0] d, input logic [15:0] m, input string tag);
    issue(1, a, d, m, tag);
  endtask
  task automatic rd(input int a, input string tag);
    issue(0, a, 8'h00, 16'h0000, tag);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got hung expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R2: clean writes then back-to-back reads
    wr(0, 8'hA5, 16'h0000, "R2");
    wr(1, 8'h3C, 16'h0000, "R2");
    wr(2, 8'hFF, 16'h0000, "R2");
    rd(0, "R2"); rd(1, "R2"); rd(2, "R2");
    // R4: single flips in low and high codewords, data and check positions
    wr(10, 8'h96, 16'h0001, "R4"); rd(10, "R4");
    wr(11, 8'h96, 16'h0020, "R4"); rd(11, "R4");
    wr(12, 8'h5A, 16'h1000, "R4"); rd(12, "R4");
    wr(13, 8'h0F, 16'h0008, "R4"); rd(13, "R4");
    // R5: adjacent storage pairs land in different codewords
    wr(20, 8'hC3, 16'h0003, "R5"); rd(20, "R5");
    wr(21, 8'h71, 16'h0300, "R5"); rd(21, "R5");
    wr(22, 8'h28, 16'h3000, "R5"); rd(22, "R5");
    // R6 and R3: double errors in one codeword return raw data bits
    wr(30, 8'h6B, 16'h0110, "R6"); rd(30, "R6");
    wr(31, 8'h6B, 16'h0A00, "R6"); rd(31, "R6");
    wr(32, 8'hE4, 16'h0005, "R3"); rd(32, "R3");
    wr(33, 8'h1D, 16'h0007, "R8"); rd(33, "R8");
    // R7: overall parity bit alone
    wr(40, 8'hB2, 16'h4000, "R7"); rd(40, "R7");
    wr(41, 8'hB2, 16'h8000, "R7"); rd(41, "R7");
    // R10: damage persists across reads, rewrite clears it
    rd(30, "R10"); rd(10, "R10");
    wr(10, 8'h44, 16'h0000, "R10"); rd(10, "R10");
    // R11: last address
    wr(DEPTH - 1, 8'h9E, 16'h0000, "R11"); rd(DEPTH - 1, "R11");
    wr(DEPTH - 2, 8'h11, 16'h0000, "R11"); rd(DEPTH - 1, "R11");
    // R9: random back-pressure over mixed traffic
    bp_mode = 1;
    for (int k = 0; k < 40; k++) begin
      rd(k % 4 == 0 ? 20 : (k % 4 == 1 ? 30 : (k % 4 == 2 ? 0 : 40)), "R9");
      if (k % 8 == 3) wr(50 + k, 8'(k * 7), 16'h0040, "R9");
    end
    for (int k = 0; k < 40; k++) if (k % 8 == 3) rd(50 + k, "R9");
    bp_mode = 0;
    repeat (6) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule